// File: doc/BRIEF.md
# Back Porch Gate Generator

This block turns a composite sync stream that has already been brought into the system clock domain into an active-low gate, one per line. The gate marks the back porch and can strobe a colour-burst sampler or a black-level clamp. Each gate is a one-shot. It begins a programmable number of clock ticks after its trigger edge, and its width is a fixed fraction of the programmed line period. Changing the line period for a different scan rate therefore rescales the gate with it.

On ordinary lines the trigger is the trailing (rising) edge of each sync pulse. While the vertical-interval indication is high, only the rising edge that ends a broad vertical pulse starts a gate, which is the leading edge of a serration. The short equalising pulses inside that interval are ignored. A rising edge that arrives while a gate is pending or active is dropped, and the running pulse completes unchanged. For a 200 MHz clock, a start delay setting of 52 ticks gives the usual delay of about 260 ns.

Top module: `bp_gate_gen`

## Requirements
- R1: A synchronous reset drives `gate_n` high and discards any pending start delay. No gate appears from a trigger edge seen before the reset.
- R2: With `vert_win` low, a rising edge of `csync_n` first sampled at clock edge P starts a gate. `gate_n` is low after clock edge P+D, where D is `start_dly`.
- R3: With `vert_win` high, a rising edge triggers only if `csync_n` was sampled low on at least `line_period >> 2` consecutive edges just before it. Shorter low runs give no gate.
- R4: The gate stays low for exactly max(1, (line_period * 7) >> 7) clock cycles, using the `line_period` present at the trigger edge.
- R5: With `start_dly` = 0, `gate_n` goes low right after the edge at which the rising edge is first sampled.
- R6: A trigger edge that arrives while a gate is delayed or active is ignored. The running gate keeps its original start and width, and no second gate follows.
- R7: `gate_n` is active low and stays high whenever no gate is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | input | 1 | Synchronised composite sync, low during sync pulses |
| vert_win | input | 1 | High during the vertical interval |
| line_period | input | LP_W | Line period in clock ticks |
| start_dly | input | DLY_W | Ticks from the trigger edge to gate start |
| gate_n | output | 1 | Back porch gate, active low |

## Verification
The hardest cases to reach from the ports are two. The first is a low run inside the vertical interval that ends exactly at the broad-pulse threshold or one tick short of it. The second is a trigger edge that falls inside the delay or the active window of a running gate. Directed sequences place a low run of 79 and then 80 ticks against a threshold of 80, and place second rising edges a few ticks into the delay and into the active phase. Constrained random frames then mix normal lines, equalising pulses, broad pulses, glitches and changing line periods and delays. Every cycle is compared with a bench-side event model.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  typedef enum logic [1:0] {
    BPG_IDLE   = 2'd0,
    BPG_DELAY  = 2'd1,
    BPG_ACTIVE = 2'd2
  } bpg_state_e;

  // Gate width: about 0.055 of a line, never below one tick.
  function automatic logic [31:0] gate_width(input logic [31:0] lp);
    logic [31:0] w;
    w = (lp * 32'd7) >> 7;
    return (w == 32'd0) ? 32'd1 : w;
  endfunction

  // Shortest low run accepted as a broad vertical pulse.
  function automatic logic [31:0] broad_min(input logic [31:0] lp);
    return lp >> 2;
  endfunction

endpackage

// File: rtl/bpg_edge_qual.sv
module bpg_edge_qual #(
  parameter int LP_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csync_n,
  input  logic            vert_win,
  input  logic [LP_W-1:0] line_period,
  output logic            trig
);
  import bpg_pkg::*;

  localparam logic [LP_W-1:0] RUN_MAX = {LP_W{1'b1}};

  logic            csync_q;
  logic [LP_W-1:0] low_run;
  logic            rise;
  logic            long_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      csync_q <= 1'b1;
      low_run <= '0;
    end else begin
      csync_q <= csync_n;
      if (!csync_n) begin
        if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
      end else begin
        low_run <= '0;
      end
    end
  end

  always_comb begin
    rise     = csync_n && !csync_q;
    long_low = 32'(low_run) >= broad_min(32'(line_period));
    trig     = rise && (!vert_win || long_low);
  end

endmodule

// File: rtl/bpg_oneshot.sv
module bpg_oneshot #(
  parameter int LP_W  = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [LP_W-1:0]  line_period,
  input  logic [DLY_W-1:0] start_dly,
  output logic             gate_act,
  output logic             busy,
  output logic [LP_W-1:0]  width_q
);
  import bpg_pkg::*;

  localparam int CW = (LP_W > DLY_W) ? LP_W : DLY_W;

  bpg_state_e      state;
  logic [CW-1:0]   cnt;
  logic [LP_W-1:0] width_now;

  assign width_now = LP_W'(gate_width(32'(line_period)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= BPG_IDLE;
      cnt     <= '0;
      width_q <= '0;
    end else begin
      case (state)
        BPG_IDLE: begin
          if (trig) begin
            width_q <= width_now;
            if (start_dly == '0) begin
              state <= BPG_ACTIVE;
              cnt   <= CW'(width_now);
            end else begin
              state <= BPG_DELAY;
              cnt   <= CW'(start_dly);
            end
          end
        end
        BPG_DELAY: begin
          if (cnt == CW'(1)) begin
            state <= BPG_ACTIVE;
            cnt   <= CW'(width_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BPG_ACTIVE: begin
          if (cnt == CW'(1)) state <= BPG_IDLE;
          else               cnt   <= cnt - 1'b1;
        end
        default: state <= BPG_IDLE;
      endcase
    end
  end

  assign gate_act = (state == BPG_ACTIVE);
  assign busy     = (state != BPG_IDLE);

endmodule

// File: rtl/bp_gate_gen.sv
module bp_gate_gen #(
  parameter int LP_W  = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csync_n,
  input  logic             vert_win,
  input  logic [LP_W-1:0]  line_period,
  input  logic [DLY_W-1:0] start_dly,
  output logic             gate_n
);

  logic            trig;
  logic            gate_act;
  logic            busy;
  logic [LP_W-1:0] width_q;

  bpg_edge_qual #(.LP_W(LP_W)) u_qual (
    .clk         (clk),
    .rst         (rst),
    .csync_n     (csync_n),
    .vert_win    (vert_win),
    .line_period (line_period),
    .trig        (trig)
  );

  bpg_oneshot #(.LP_W(LP_W), .DLY_W(DLY_W)) u_shot (
    .clk         (clk),
    .rst         (rst),
    .trig        (trig),
    .line_period (line_period),
    .start_dly   (start_dly),
    .gate_act    (gate_act),
    .busy        (busy),
    .width_q     (width_q)
  );

  assign gate_n = !gate_act;

endmodule

// File: rtl/bpg_chk.sv
module bpg_chk #(
  parameter int LP_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            csync_n,
  input logic            trig,
  input logic            busy,
  input logic            gate_n,
  input logic [LP_W-1:0] width_q
);

  logic          rst_q;
  logic [LP_W:0] lo_cnt;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)         lo_cnt <= '0;
    else if (!gate_n) lo_cnt <= lo_cnt + 1'b1;
    else             lo_cnt <= '0;
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst_q) r1_reset_chk: assert (gate_n);
  end

  // R2
  r2_trig_edge_chk: assert property (@(posedge clk) disable iff (rst)
    trig |-> (csync_n && !$past(csync_n)));

  // R4
  r4_width_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_n && lo_cnt != '0) |-> (lo_cnt == {1'b0, width_q}));

  // R5
  r5_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_n) |-> ($past(busy) || $past(trig)));

endmodule

bind bp_gate_gen bpg_chk #(.LP_W(LP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .csync_n (csync_n),
  .trig    (trig),
  .busy    (busy),
  .gate_n  (gate_n),
  .width_q (width_q)
);

// File: tb/tb_bp_gate_gen.sv
`timescale 1ns/1ps
module tb_bp_gate_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csync_n = 1'b1;
  logic        vert_win = 1'b0;
  logic [15:0] line_period = 16'd320;
  logic [7:0]  start_dly = 8'd4;
  logic        gate_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int low_count = 0;

  int m_prev = 1, m_run = 0, m_start = 0, m_end = 0;
  string m_tag = "R7";

  always #2.5 clk = ~clk;

  bp_gate_gen dut (
    .clk(clk), .rst(rst), .csync_n(csync_n), .vert_win(vert_win),
    .line_period(line_period), .start_dly(start_dly), .gate_n(gate_n)
  );

  function automatic int exp_width(int lp);
    int w = (lp * 7) / 128;
    return (w < 1) ? 1 : w;
  endfunction

  // Bench event model, sampled at the rising edge.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_prev = 1; m_run = 0; m_start = 0; m_end = 0; m_tag = "R1";
    end else begin
      if (!csync_n) m_run++;
      else begin
        if (m_prev == 0 && (!vert_win || m_run >= int'(line_period) / 4)
            && cyc > m_end) begin
          m_start = cyc + int'(start_dly);
          m_end   = m_start + exp_width(int'(line_period));
          m_tag   = vert_win ? "R3" : ((start_dly == 0) ? "R5" : "R2/R4");
        end
        m_run = 0;
      end
      m_prev = csync_n;
    end
  end

  always @(negedge clk) begin
    logic e;
    if (cyc > 0) begin
      e = (cyc >= m_start && cyc < m_end) ? 1'b0 : 1'b1;
      checks++;
      if (gate_n !== e) begin
        failures++;
        $display("FAIL %s/R6 cycle %0d act=%b exp=%b", m_tag, cyc, gate_n, e);
      end
      if (!gate_n) low_count++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      csync_n = v;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4581));
    repeat (4) @(negedge clk);
    chk(gate_n == 1'b1, "R1 reset level", gate_n, 1);
    rst = 1'b0;

    // R7: idle output stays high
    low_count = 0;
    drive(1, 20);
    chk(low_count == 0, "R7 idle", low_count, 0);

    // R2 start position, R4 width (lp=320 -> 17)
    low_count = 0;
    drive(0, 6);
    drive(1, 1);
    repeat (4) @(negedge clk);
    chk(gate_n == 1'b1, "R2 before delay", gate_n, 1);
    @(negedge clk);
    chk(gate_n == 1'b0, "R2 start at P+D", gate_n, 0);
    drive(1, 40);
    chk(low_count == 17, "R4 width lp=320", low_count, 17);

    // R6: edge during active phase
    low_count = 0;
    drive(0, 6); drive(1, 8); drive(0, 2); drive(1, 40);
    chk(low_count == 17, "R6 retrigger in active", low_count, 17);
    // R6: edge during delay phase
    low_count = 0;
    drive(0, 6); drive(1, 2); drive(0, 1); drive(1, 40);
    chk(low_count == 17, "R6 retrigger in delay", low_count, 17);

    // R5: zero delay
    start_dly = 8'd0;
    drive(0, 5);
    drive(1, 1);
    @(negedge clk);
    chk(gate_n == 1'b0, "R5 immediate start", gate_n, 0);
    drive(1, 30);

    // R3: vertical window threshold lp>>2 = 80
    vert_win = 1'b1;
    start_dly = 8'd3;
    low_count = 0;
    drive(0, 20); drive(1, 40);
    chk(low_count == 0, "R3 equalising ignored", low_count, 0);
    low_count = 0;
    drive(0, 79); drive(1, 40);
    chk(low_count == 0, "R3 run 79 below threshold", low_count, 0);
    low_count = 0;
    drive(0, 80); drive(1, 40);
    chk(low_count == 17, "R3 run 80 at threshold", low_count, 17);
    vert_win = 1'b0;

    // R1: reset during pending delay
    start_dly = 8'd10;
    low_count = 0;
    drive(0, 6); drive(1, 3);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(1, 30);
    chk(low_count == 0, "R1 pending delay cleared", low_count, 0);

    // R4: other line periods, including the one-tick floor
    start_dly = 8'd0;
    line_period = 16'd1000;
    low_count = 0;
    drive(0, 6); drive(1, 80);
    chk(low_count == 54, "R4 width lp=1000", low_count, 54);
    line_period = 16'd10;
    low_count = 0;
    drive(0, 3); drive(1, 10);
    chk(low_count == 1, "R4 width floor", low_count, 1);

    // Random frames checked by the model every cycle
    for (int f = 0; f < 8; f++) begin
      line_period = 16'(160 + $urandom_range(0, 320));
      start_dly   = 8'($urandom_range(0, 12));
      for (int l = 0; l < 10; l++) begin
        int lo = 5 + $urandom_range(0, 20);
        drive(0, lo);
        if ($urandom_range(0, 3) == 0) begin
          drive(1, $urandom_range(1, 25));
          drive(0, $urandom_range(1, 4));
        end
        drive(1, int'(line_period) - lo);
      end
      vert_win = 1'b1;
      for (int k = 0; k < 18; k++) begin
        int half = int'(line_period) / 2;
        if (k >= 6 && k < 12) begin
          drive(0, half - 8); drive(1, 8);
        end else begin
          int eq = $urandom_range(3, 6);
          drive(0, eq); drive(1, half - eq);
        end
      end
      vert_win = 1'b0;
    end
    drive(1, 200);
    finish_run();
  end

endmodule